// File: doc/BRIEF.md
# Bit-Serial Page-Mode DRAM Byte Controller

This block gives an 8-bit processor a byte-wide memory of 32K locations built from one dynamic RAM that is only one bit wide (256K x 1). Each processor byte is spread over eight neighbouring cells of a single DRAM row. An access opens that row once. It then runs eight page-mode column cycles, one per data bit, before it closes the row again.

On a write, an 8:1 selector picks the bit that matches the current bit index from the latched processor byte and drives it to the DRAM data pin. On a read, each DRAM output bit is stored in an internal holding register. The finished byte is copied to the read-data port only when all eight bits are in. The processor holds its request until a one-cycle ready pulse. All DRAM timing intervals are counted in system clock cycles and set by parameters.

Top module: `dram_bitser_ctrl`

## Requirements
- R1: While reset is asserted and right after it, RAS, CAS and WE are high (inactive), ready is low and read data is 0.
- R2: The DRAM address present when RAS falls is request address bits [14:6]. RAS falls exactly once per access. Bit b of the byte at address A is held in the DRAM cell whose 18-bit index is {A, b}.
- R3: During one RAS-low period, CAS falls exactly eight times and only while RAS is low. At the n-th CAS fall (n = 0..7) the DRAM address is {request address bits [5:0], n[2:0]}. The address stays stable while CAS is low.
- R4: On writes, WE is low from the RAS fall through every CAS-low cycle, and the DRAM data input at the n-th CAS fall equals bit n of the write byte. On reads, WE stays high.
- R5: On reads, bit n of the read-data port equals the DRAM output bit sampled in column cycle n. The read-data port changes only in the cycle where ready is high, and write accesses leave it unchanged.
- R6: Ready is high for exactly one cycle. It rises T_RCD + 8*T_CAS + 7*T_CP + T_RP clock edges after the edge that accepts the request.
- R7: The first CAS fall comes exactly T_RCD cycles after the RAS fall. Each CAS-low pulse lasts exactly T_CAS cycles. RAS stays high for at least T_RP cycles before any new RAS fall.
- R8: A request that is still high during the ready cycle does not start a second access. A new access begins only when the request is seen with the block idle and ready low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, held until ready |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 15 | Byte address |
| req_wdata_i | input | 8 | Write byte |
| rdy_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Read byte, updated on read completion |
| dram_a_o | output | 9 | Multiplexed row/column address |
| dram_ras_n_o | output | 1 | Row strobe, active low |
| dram_cas_n_o | output | 1 | Column strobe, active low |
| dram_we_n_o | output | 1 | Write enable, active low |
| dram_d_o | output | 1 | Data bit to the DRAM |
| dram_q_i | input | 1 | Data bit from the DRAM |

## Verification
A bit index that is off by one in the internal counter shows up at the very next CAS fall, as a wrong low column bit or a wrong write-data bit. The same fault sends a byte to the wrong cells, and that becomes visible when the byte is read back. A wrong timing counter or a missed state shows within one access as a changed RAS-to-CAS spacing, a wrong CAS pulse width or a wrong ready latency. A gather register that is updated or exposed too early changes the read-data port before the ready pulse. An acceptance path that ignores the ready cycle produces a second RAS fall a few cycles after ready.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_RCD  = 3'd1,
      ST_CASL = 3'd2,
      ST_CASH = 3'd3,
      ST_PRE  = 3'd4
   } dbc_state_e;
endpackage

// File: rtl/dbc_addr_mux.sv
module dbc_addr_mux #(
   parameter int ROW_W    = 9,
   parameter int COL_HI_W = 6,
   parameter int IDX_W    = 3
) (
   input  logic [ROW_W-1:0]    row_i,
   input  logic [COL_HI_W-1:0] col_hi_i,
   input  logic [IDX_W-1:0]    idx_i,
   input  logic                col_sel_i,
   output logic [ROW_W-1:0]    a_o
);
   localparam int COL_W = COL_HI_W + IDX_W;
   logic [COL_W-1:0] col_full;

   assign col_full = {col_hi_i, idx_i};

   generate
      if (COL_W == ROW_W) begin : g_eq
         assign a_o = col_sel_i ? col_full : row_i;
      end else begin : g_pad
         assign a_o = col_sel_i ? ROW_W'(col_full) : row_i;
      end
   endgenerate
endmodule

// File: rtl/dbc_bit_sel.sv
module dbc_bit_sel #(
   parameter int IDX_W = 3
) (
   input  logic [(1<<IDX_W)-1:0] data_i,
   input  logic [IDX_W-1:0]      idx_i,
   output logic                  bit_o
);
   localparam int DATA_W = 1 << IDX_W;
   logic [DATA_W-1:0] hit;

   generate
      for (genvar k = 0; k < DATA_W; k++) begin : g_leg
         assign hit[k] = data_i[k] & (idx_i == IDX_W'(k));
      end
   endgenerate

   assign bit_o = |hit;
endmodule

// File: rtl/dbc_gather.sv
module dbc_gather #(
   parameter int IDX_W = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cap_en_i,
   input  logic [IDX_W-1:0]      idx_i,
   input  logic                  bit_i,
   input  logic                  done_i,
   output logic [(1<<IDX_W)-1:0] byte_o
);
   localparam int DATA_W = 1 << IDX_W;
   logic [DATA_W-1:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         byte_o <= '0;
      end else begin
         if (cap_en_i) hold_q[idx_i] <= bit_i;
         if (done_i)   byte_o <= hold_q;
      end
   end
endmodule

// File: rtl/dram_bitser_ctrl.sv
module dram_bitser_ctrl
   import dbc_pkg::*;
#(
   parameter int ROW_W    = 9,
   parameter int COL_HI_W = 6,
   parameter int IDX_W    = 3,
   parameter int T_RCD    = 2,
   parameter int T_CAS    = 2,
   parameter int T_CP     = 1,
   parameter int T_RP     = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         req_i,
   input  logic                         req_we_i,
   input  logic [ROW_W+COL_HI_W-1:0]    req_addr_i,
   input  logic [(1<<IDX_W)-1:0]        req_wdata_i,
   output logic                         rdy_o,
   output logic [(1<<IDX_W)-1:0]        rdata_o,
   output logic [ROW_W-1:0]             dram_a_o,
   output logic                         dram_ras_n_o,
   output logic                         dram_cas_n_o,
   output logic                         dram_we_n_o,
   output logic                         dram_d_o,
   input  logic                         dram_q_i
);
   localparam int DATA_W = 1 << IDX_W;
   localparam int ADDR_W = ROW_W + COL_HI_W;
   localparam int T_M1   = (T_RCD > T_CAS) ? T_RCD : T_CAS;
   localparam int T_M2   = (T_CP > T_RP) ? T_CP : T_RP;
   localparam int T_MAX  = (T_M1 > T_M2) ? T_M1 : T_M2;
   localparam int CNT_W  = (T_MAX < 2) ? 1 : $clog2(T_MAX);

   generate
      if (T_RCD < 1 || T_CAS < 1 || T_CP < 1 || T_RP < 1) begin : g_bad_timing
         $error("timing parameters must be at least one cycle");
      end
      if (COL_HI_W + IDX_W > ROW_W) begin : g_bad_col
         $error("column address does not fit the DRAM address bus");
      end
   endgenerate

   dbc_state_e         state_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [IDX_W-1:0]   idx_q;
   logic [ADDR_W-1:0]  addr_q;
   logic               we_q;
   logic [DATA_W-1:0]  wdata_q;
   logic               rdy_q;
   logic               slot_end;
   logic               last_bit;
   logic               row_open;
   logic               col_sel;
   logic               cap_en;
   logic               rd_done;

   assign slot_end = (cnt_q == '0);
   assign last_bit = (idx_q == '1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         idx_q   <= '0;
         addr_q  <= '0;
         we_q    <= 1'b0;
         wdata_q <= '0;
         rdy_q   <= 1'b0;
      end else begin
         rdy_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (req_i && !rdy_q) begin
                  addr_q  <= req_addr_i;
                  we_q    <= req_we_i;
                  wdata_q <= req_wdata_i;
                  idx_q   <= '0;
                  cnt_q   <= CNT_W'(T_RCD - 1);
                  state_q <= ST_RCD;
               end
            end
            ST_RCD: begin
               if (slot_end) begin
                  cnt_q   <= CNT_W'(T_CAS - 1);
                  state_q <= ST_CASL;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            ST_CASL: begin
               if (slot_end) begin
                  if (last_bit) begin
                     cnt_q   <= CNT_W'(T_RP - 1);
                     state_q <= ST_PRE;
                  end else begin
                     idx_q   <= idx_q + 1'b1;
                     cnt_q   <= CNT_W'(T_CP - 1);
                     state_q <= ST_CASH;
                  end
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            ST_CASH: begin
               if (slot_end) begin
                  cnt_q   <= CNT_W'(T_CAS - 1);
                  state_q <= ST_CASL;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            ST_PRE: begin
               if (slot_end) begin
                  rdy_q   <= 1'b1;
                  state_q <= ST_IDLE;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign row_open     = (state_q == ST_RCD) || (state_q == ST_CASL) || (state_q == ST_CASH);
   assign col_sel      = (state_q == ST_CASL) || (state_q == ST_CASH);
   assign dram_ras_n_o = !row_open;
   assign dram_cas_n_o = (state_q != ST_CASL);
   assign dram_we_n_o  = !(row_open && we_q);
   assign cap_en       = (state_q == ST_CASL) && slot_end && !we_q;
   assign rd_done      = (state_q == ST_PRE) && slot_end && !we_q;
   assign rdy_o        = rdy_q;

   dbc_addr_mux #(
      .ROW_W    (ROW_W),
      .COL_HI_W (COL_HI_W),
      .IDX_W    (IDX_W)
   ) amux_i (
      .row_i     (addr_q[ADDR_W-1 -: ROW_W]),
      .col_hi_i  (addr_q[COL_HI_W-1:0]),
      .idx_i     (idx_q),
      .col_sel_i (col_sel),
      .a_o       (dram_a_o)
   );

   dbc_bit_sel #(
      .IDX_W (IDX_W)
   ) wsel_i (
      .data_i (wdata_q),
      .idx_i  (idx_q),
      .bit_o  (dram_d_o)
   );

   dbc_gather #(
      .IDX_W (IDX_W)
   ) gath_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_en_i (cap_en),
      .idx_i    (idx_q),
      .bit_i    (dram_q_i),
      .done_i   (rd_done),
      .byte_o   (rdata_o)
   );
endmodule

// File: rtl/dbc_checker.sv
module dbc_checker #(
   parameter int DA_W   = 9,
   parameter int DATA_W = 8,
   parameter int T_CAS  = 2,
   parameter int T_RP   = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ras_n,
   input logic              cas_n,
   input logic              we_n,
   input logic [DA_W-1:0]   a,
   input logic              rdy,
   input logic [DATA_W-1:0] rdata
);
   logic [7:0] cas_lo_cnt;
   logic [7:0] ras_hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cas_lo_cnt <= '0;
         ras_hi_cnt <= 8'hFF;
      end else begin
         cas_lo_cnt <= cas_n ? 8'd0 : ((cas_lo_cnt == 8'hFF) ? cas_lo_cnt : cas_lo_cnt + 8'd1);
         ras_hi_cnt <= !ras_n ? 8'd0 : ((ras_hi_cnt == 8'hFF) ? ras_hi_cnt : ras_hi_cnt + 8'd1);
      end
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         AST_RESET_QUIET: assert (ras_n && cas_n && we_n && !rdy); // R1
      end
   end

   AST_CAS_INSIDE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
      !cas_n |-> !ras_n); // R3

   AST_COL_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!cas_n && !$past(cas_n)) |-> $stable(a)); // R3

   AST_WE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!cas_n && !$past(cas_n)) |-> $stable(we_n)); // R4

   AST_RDY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rdy |=> !rdy); // R6

   AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !rdy |-> $stable(rdata)); // R5

   AST_CAS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cas_n) |-> (cas_lo_cnt == 8'(T_CAS))); // R7

   AST_RAS_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> (ras_hi_cnt >= 8'(T_RP))); // R7
endmodule

bind dram_bitser_ctrl dbc_checker #(
   .DA_W   (ROW_W),
   .DATA_W (1 << IDX_W),
   .T_CAS  (T_CAS),
   .T_RP   (T_RP)
) chk_i (
   .clk   (clk),
   .rst_n (rst_n),
   .ras_n (dram_ras_n_o),
   .cas_n (dram_cas_n_o),
   .we_n  (dram_we_n_o),
   .a     (dram_a_o),
   .rdy   (rdy_o),
   .rdata (rdata_o)
);

// File: tb/dram_bitser_ctrl_tb_top.sv
`timescale 1ns/1ps
module dram_bitser_ctrl_tb_top;
   localparam int T_RCD = 2;
   localparam int T_CAS = 2;
   localparam int T_CP  = 1;
   localparam int T_RP  = 2;
   localparam int LAT   = T_RCD + 8*T_CAS + 7*T_CP + T_RP;
   localparam int NACC  = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic        req_we = 1'b0;
   logic [14:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        rdy;
   logic [7:0]  rdata;
   logic [8:0]  da;
   logic        ras_n, cas_n, we_n, dd;
   logic        dq = 1'b0;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   dram_bitser_ctrl #(
      .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .req_i(req), .req_we_i(req_we),
      .req_addr_i(req_addr), .req_wdata_i(req_wdata), .rdy_o(rdy),
      .rdata_o(rdata), .dram_a_o(da), .dram_ras_n_o(ras_n),
      .dram_cas_n_o(cas_n), .dram_we_n_o(we_n), .dram_d_o(dd),
      .dram_q_i(dq)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // DRAM model and strobe monitor
   bit          dmem [int];
   logic [14:0] exp_addr = '0;
   logic        exp_we = 1'b0;
   logic [7:0]  exp_wdata = '0;
   logic [8:0]  row_l = '0;
   bit          prev_ras = 1'b1, prev_cas = 1'b1;
   int          cyc = 0, t_ras_fall = 0, t_ras_rise = -100, t_cas_fall = 0;
   int          cas_idx = 0, ras_falls = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         if (prev_ras && !ras_n) begin
            ras_falls++;
            row_l = da;
            chk(da == exp_addr[14:6], "R2 row address", int'(da), int'(exp_addr[14:6]));
            chk(cyc - t_ras_rise >= T_RP, "R7 RAS precharge", cyc - t_ras_rise, T_RP);
            chk(we_n == !exp_we, "R4 WE at RAS fall", int'(we_n), int'(!exp_we));
            t_ras_fall = cyc;
            cas_idx = 0;
         end
         if (!prev_ras && ras_n) begin
            t_ras_rise = cyc;
            chk(cas_idx == 8, "R3 CAS count", cas_idx, 8);
         end
         if (prev_cas && !cas_n) begin
            chk(!ras_n, "R3 CAS inside RAS", int'(ras_n), 0);
            chk(da == {exp_addr[5:0], 3'(cas_idx)}, "R3 column address",
                int'(da), int'({exp_addr[5:0], 3'(cas_idx)}));
            if (cas_idx == 0)
               chk(cyc - t_ras_fall == T_RCD, "R7 RAS to CAS", cyc - t_ras_fall, T_RCD);
            chk(we_n == !exp_we, "R4 WE at CAS", int'(we_n), int'(!exp_we));
            if (exp_we) begin
               chk(dd == exp_wdata[cas_idx[2:0]], "R4 write bit", int'(dd),
                   int'(exp_wdata[cas_idx[2:0]]));
               dmem[int'({row_l, da})] = dd;
            end
            t_cas_fall = cyc;
            cas_idx++;
         end
         if (!prev_cas && cas_n)
            chk(cyc - t_cas_fall == T_CAS, "R7 CAS width", cyc - t_cas_fall, T_CAS);
         if (!cas_n && we_n)
            dq = dmem.exists(int'({row_l, da})) ? dmem[int'({row_l, da})] : 1'b0;
         prev_ras = ras_n;
         prev_cas = cas_n;
      end
   end

   logic [7:0] shadow [int];

   task automatic access(input bit we, input logic [14:0] addr, input logic [7:0] wd, input bit hold);
      int n;
      logic [7:0] old;
      exp_addr  = addr;
      exp_we    = we;
      exp_wdata = wd;
      ras_falls = 0;
      old       = rdata;
      req_we    = we;
      req_addr  = addr;
      req_wdata = wd;
      req       = 1'b1;
      n = 0;
      do begin
         @(negedge clk);
         n++;
         if (!rdy && rdata != old)
            chk(1'b0, "R5 early read data", int'(rdata), int'(old));
      end while (!rdy && n < 200);
      chk(n == LAT + 1, "R6 ready latency", n - 1, LAT);
      if (we) begin
         chk(rdata == old, "R5 write keeps read data", int'(rdata), int'(old));
         shadow[int'(addr)] = wd;
         for (int b = 0; b < 8; b++)
            chk(dmem.exists(int'({addr, 3'(b)})) && dmem[int'({addr, 3'(b)})] == wd[b],
                "R2 cell mapping", int'(dmem.exists(int'({addr, 3'(b)})) ? dmem[int'({addr, 3'(b)})] : 1'b0),
                int'(wd[b]));
      end else begin
         chk(rdata == shadow[int'(addr)], "R5 read back", int'(rdata), int'(shadow[int'(addr)]));
      end
      if (hold) begin
         @(negedge clk);
         chk(!rdy, "R6 ready single", int'(rdy), 0);
      end
      req = 1'b0;
      @(negedge clk);
      chk(!rdy, "R6 ready low after", int'(rdy), 0);
      repeat (3) @(negedge clk);
      chk(ras_falls == 1, "R8 one access per request", ras_falls, 1);
   endtask

   function automatic logic [14:0] sweep_addr(input int i);
      if (i == NACC - 1) return 15'h7FFF;
      return 15'((i * 517 + i * i * 13) & 16'h7FFF);
   endfunction

   function automatic logic [7:0] sweep_data(input int i);
      if (i == 1) return 8'hFF;
      if (i == 2) return 8'h00;
      return 8'((i * 37 + 5) & 8'hFF);
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      chk(ras_n && cas_n && we_n, "R1 strobes in reset", int'({ras_n, cas_n, we_n}), 7);
      chk(!rdy && rdata == 8'h00, "R1 ready/data in reset", int'({rdy, rdata}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ras_n && cas_n && we_n && !rdy, "R1 idle after reset",
          int'({ras_n, cas_n, we_n, rdy}), 14);
      for (int i = 0; i < NACC; i++)
         access(1'b1, sweep_addr(i), sweep_data(i), (i % 3) == 0);
      for (int i = NACC - 1; i >= 0; i--)
         access(1'b0, sweep_addr(i), 8'h00, (i % 2) == 0);
      // overwrite with complement and read again
      for (int i = 0; i < 8; i++) begin
         access(1'b1, sweep_addr(i * 7), ~sweep_data(i * 7), 1'b0);
         access(1'b0, sweep_addr(i * 7), 8'h00, 1'b1);
      end
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end
endmodule